// File: doc/BRIEF.md
# Expansion Card Address Decoder (IDE + SCSI)

This block sits behind the slave port of a 64 KB expansion window on a 16-bit big-endian host bus. Each host access carries a 16-bit offset, a read/write flag and a byte/word flag. Every byte is routed to one of five targets: an IDE task-file port with a primary and a secondary channel select, a SCSI controller register region, a small DMA/control register block, an inverted SCSI-ID byte, or a boot ROM. Offsets that reach none of them read as 0xFF, and writes to them have no effect.

The IDE data register is the only 16-bit target. A word access to it completes in one beat. Any other word access becomes two byte beats on consecutive cycles: the high byte at the offset, then the low byte at the offset plus one, with the offset wrapping within 16 bits. All targets take a single-cycle access with no handshake. The host sees `ready_o` low during the second beat. `done_o` pulses in the cycle after the last beat, with read data in `rdata_o`.

A strap input says whether the SCSI part is fitted (1 = IDE plus SCSI, 0 = IDE only). A second strap carries the 3-bit SCSI bus ID.

Top module: `exp_card_decoder`

## Requirements
- R1: During and after reset, with no request, `ready_o`=1, `done_o`=0, `rdata_o`=0 and no target strobe is active.
- R2: A byte access at an odd offset with bit 11 set and bit 15 clear strobes the IDE port. The register index is offset bits 8:6. Offset bit 9 selects channel: 0 gives `ide_cs_o`=2'b01 (primary), 1 gives 2'b10 (secondary). A byte read returns `ide_rdata_i[7:0]`.
- R3: A byte access at an even offset, or with offset bit 11 clear, never strobes the IDE port.
- R4: Offsets 0x0000–0x00FF address the SCSI region with `scsi_addr_o` = offset[7:0], but only when `scsi_fitted_i`=1. When it is 0, reads there return 0xFF and no SCSI strobe occurs.
- R5: A byte read at 0x0401 returns `{5'b0, ~scsi_id_i}` when the SCSI part is fitted, and 0xFF when it is not.
- R6: Offsets with bit 15 set read the ROM at `rom_addr_o` = offset[14:0]. In that region the IDE port is never strobed and writes strobe nothing.
- R7: A word access at an offset with bit 11 set, bit 15 clear and bits 8:6 zero is a single 16-bit IDE data transfer (`ide_word_o`=1). A read returns `ide_rdata_i`, and a write drives `wdata_i` on `ide_wdata_o`.
- R8: Every other word access takes two byte beats, each decoded like a byte access. The high byte (`wdata_i[15:8]`) goes to the offset and the low byte to the offset plus one, modulo 2^16. `ready_o` is 0 during the second beat. A read returns {first byte, second byte}.
- R9: Byte writes to 0x0400–0x0407 strobe `ctl_wr_o` with `ctl_addr_o` = offset[2:0] and the data byte, whatever the SCSI strap.
- R10: Reads of unmapped offsets return 0xFF. Writes to unmapped offsets strobe nothing.
- R11: `done_o` pulses for one cycle, at the clock edge that ends the last beat of an access. Byte reads return the byte in `rdata_o[7:0]` with `rdata_o[15:8]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scsi_fitted_i | input | 1 | Strap: 1 = SCSI part present |
| scsi_id_i | input | 3 | Strap: SCSI bus ID |
| req_i | input | 1 | Access request, accepted when ready_o is 1 |
| we_i | input | 1 | 1 = write |
| word_i | input | 1 | 1 = word access, 0 = byte |
| off_i | input | 16 | Offset inside the window |
| wdata_i | input | 16 | Write data (byte writes use [7:0]) |
| ready_o | output | 1 | Decoder can accept a request |
| done_o | output | 1 | Access finished |
| rdata_o | output | 16 | Read data, valid with done_o |
| ide_rd_o | output | 1 | IDE read strobe |
| ide_wr_o | output | 1 | IDE write strobe |
| ide_word_o | output | 1 | IDE 16-bit data transfer |
| ide_cs_o | output | 2 | IDE channel select, one-hot |
| ide_reg_o | output | 3 | IDE register index |
| ide_wdata_o | output | 16 | IDE write data |
| ide_rdata_i | input | 16 | IDE read data |
| scsi_rd_o | output | 1 | SCSI read strobe |
| scsi_wr_o | output | 1 | SCSI write strobe |
| scsi_addr_o | output | 8 | SCSI register offset |
| scsi_wdata_o | output | 8 | SCSI write data |
| scsi_rdata_i | input | 8 | SCSI read data |
| ctl_wr_o | output | 1 | Control block write strobe |
| ctl_addr_o | output | 3 | Control register select |
| ctl_wdata_o | output | 8 | Control write data |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | 15 | ROM byte address |
| rom_rdata_i | input | 8 | ROM read data |

## Verification
The bench uses the default parameters: a 16-bit offset, a 3-bit ID and an 8-bit SCSI span. With these, the first 4 KB of the window can be swept byte by byte in both strap settings, for reads and for writes. That sweep covers every IDE register and channel, the odd/even rule, the SCSI span edge at 0xFF/0x100, the control range and the ID byte, and it checks both the data and the full strobe pattern at each offset. Target models in the bench derive their read data from the decoded address, so a wrong register index, channel or ROM address shows up as wrong data. Directed word accesses cover the single-beat data register, split reads and writes, and the wrap at 0xFFFF.

// File: rtl/exp_dec_pkg.sv
package exp_dec_pkg;
  typedef enum logic [2:0] {
    T_NONE,
    T_IDE,
    T_SCSI,
    T_ID,
    T_CTL,
    T_ROM
  } tgt_e;
endpackage

// File: rtl/exp_byte_route.sv
module exp_byte_route
  import exp_dec_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int ID_W        = 3,
  parameter int IDE_EN_BIT  = 11,
  parameter int IDE_SEC_BIT = 9,
  parameter int IDE_REG_LSB = 6,
  parameter int IDE_REG_W   = 3,
  parameter int ROM_BIT     = 15,
  parameter int SCSI_AW     = 8,
  parameter int CTL_AW      = 3,
  parameter logic [OFF_W-1:0] CTL_BASE = 16'h0400,
  parameter logic [OFF_W-1:0] ID_OFF   = 16'h0401
) (
  input  logic                 act_i,
  input  logic                 we_i,
  input  logic                 word_data_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [7:0]           wbyte_i,
  input  logic [15:0]          wword_i,
  input  logic                 scsi_fitted_i,
  input  logic [ID_W-1:0]      scsi_id_i,
  output logic                 ide_rd_o,
  output logic                 ide_wr_o,
  output logic                 ide_word_o,
  output logic [1:0]           ide_cs_o,
  output logic [IDE_REG_W-1:0] ide_reg_o,
  output logic [15:0]          ide_wdata_o,
  input  logic [15:0]          ide_rdata_i,
  output logic                 scsi_rd_o,
  output logic                 scsi_wr_o,
  output logic [SCSI_AW-1:0]   scsi_addr_o,
  output logic [7:0]           scsi_wdata_o,
  input  logic [7:0]           scsi_rdata_i,
  output logic                 ctl_wr_o,
  output logic [CTL_AW-1:0]    ctl_addr_o,
  output logic [7:0]           ctl_wdata_o,
  output logic                 rom_rd_o,
  output logic [ROM_BIT-1:0]   rom_addr_o,
  input  logic [7:0]           rom_rdata_i,
  output logic [7:0]           rbyte_o
);
  localparam logic [OFF_W-1:0] CTL_TAG = CTL_BASE >> CTL_AW;

  tgt_e tgt;
  logic rom_hit, ide_hit, scsi_hit, ctl_hit, id_hit;

  always_comb begin
    rom_hit  = off_i[ROM_BIT];
    ide_hit  = off_i[IDE_EN_BIT] && off_i[0] && !rom_hit;
    scsi_hit = ((off_i >> SCSI_AW) == '0) && scsi_fitted_i;
    ctl_hit  = (off_i >> CTL_AW) == CTL_TAG;
    id_hit   = (off_i == ID_OFF) && scsi_fitted_i;
    tgt = T_NONE;
    if (word_data_i)   tgt = T_IDE;
    else if (rom_hit)  tgt = we_i ? T_NONE : T_ROM;
    else if (scsi_hit) tgt = T_SCSI;
    else if (we_i && ctl_hit) tgt = T_CTL;
    else if (!we_i && id_hit) tgt = T_ID;
    else if (ide_hit)  tgt = T_IDE;
  end

  // strobes
  assign ide_rd_o   = act_i && (tgt == T_IDE)  && !we_i;
  assign ide_wr_o   = act_i && (tgt == T_IDE)  &&  we_i;
  assign ide_word_o = act_i && word_data_i;
  assign scsi_rd_o  = act_i && (tgt == T_SCSI) && !we_i;
  assign scsi_wr_o  = act_i && (tgt == T_SCSI) &&  we_i;
  assign ctl_wr_o   = act_i && (tgt == T_CTL);
  assign rom_rd_o   = act_i && (tgt == T_ROM);

  assign ide_cs_o     = (act_i && tgt == T_IDE) ? (off_i[IDE_SEC_BIT] ? 2'b10 : 2'b01) : 2'b00;
  assign ide_reg_o    = off_i[IDE_REG_LSB +: IDE_REG_W];
  assign ide_wdata_o  = word_data_i ? wword_i : {8'h00, wbyte_i};
  assign scsi_addr_o  = off_i[SCSI_AW-1:0];
  assign scsi_wdata_o = wbyte_i;
  assign ctl_addr_o   = off_i[CTL_AW-1:0];
  assign ctl_wdata_o  = wbyte_i;
  assign rom_addr_o   = off_i[ROM_BIT-1:0];

  always_comb begin
    unique case (tgt)
      T_IDE:   rbyte_o = ide_rdata_i[7:0];
      T_SCSI:  rbyte_o = scsi_rdata_i;
      T_ID:    rbyte_o = {{(8-ID_W){1'b0}}, ~scsi_id_i};
      T_ROM:   rbyte_o = rom_rdata_i;
      default: rbyte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/exp_beat_seq.sv
module exp_beat_seq #(
  parameter int OFF_W       = 16,
  parameter int IDE_EN_BIT  = 11,
  parameter int IDE_REG_LSB = 6,
  parameter int IDE_REG_W   = 3,
  parameter int ROM_BIT     = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             word_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [15:0]      wdata_i,
  output logic             ready_o,
  output logic             beat_act_o,
  output logic             beat_we_o,
  output logic [OFF_W-1:0] beat_off_o,
  output logic [7:0]       beat_wbyte_o,
  output logic             beat_word_data_o,
  output logic             beat_last_o,
  output logic             beat_hi_o,
  output logic             beat_lo_o
);
  logic             second_q;
  logic [OFF_W-1:0] off_q;
  logic             we_q;
  logic [7:0]       lo_q;
  logic             data_word, split, take;

  assign data_word = word_i && off_i[IDE_EN_BIT] && !off_i[ROM_BIT]
                     && (off_i[IDE_REG_LSB +: IDE_REG_W] == '0);
  assign take  = req_i && !second_q;
  assign split = take && word_i && !data_word;

  always_comb begin
    if (second_q) begin
      beat_act_o       = 1'b1;
      beat_we_o        = we_q;
      beat_off_o       = off_q;
      beat_wbyte_o     = lo_q;
      beat_word_data_o = 1'b0;
      beat_last_o      = 1'b1;
      beat_hi_o        = 1'b0;
    end else begin
      beat_act_o       = take;
      beat_we_o        = we_i;
      beat_off_o       = off_i;
      beat_wbyte_o     = word_i ? wdata_i[15:8] : wdata_i[7:0];
      beat_word_data_o = take && data_word;
      beat_last_o      = take && !split;
      beat_hi_o        = split;
    end
  end

  assign beat_lo_o = second_q;
  assign ready_o   = !second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      off_q    <= '0;
      we_q     <= 1'b0;
      lo_q     <= '0;
    end else begin
      second_q <= split;
      if (split) begin
        off_q <= off_i + 1'b1;
        we_q  <= we_i;
        lo_q  <= wdata_i[7:0];
      end
    end
  end
endmodule

// File: rtl/exp_resp_reg.sv
module exp_resp_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        beat_act_i,
  input  logic        beat_we_i,
  input  logic        beat_last_i,
  input  logic        beat_hi_i,
  input  logic        beat_lo_i,
  input  logic        beat_word_data_i,
  input  logic [7:0]  rbyte_i,
  input  logic [15:0] ide_rdata_i,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  logic [7:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= beat_act_i && beat_last_i;
      if (beat_act_i && beat_hi_i && !beat_we_i) hi_q <= rbyte_i;
      if (beat_act_i && beat_last_i && !beat_we_i) begin
        if (beat_word_data_i) rdata_o <= ide_rdata_i;
        else if (beat_lo_i)   rdata_o <= {hi_q, rbyte_i};
        else                  rdata_o <= {8'h00, rbyte_i};
      end
    end
  end
endmodule

// File: rtl/exp_card_decoder.sv
module exp_card_decoder #(
  parameter int OFF_W       = 16,
  parameter int ID_W        = 3,
  parameter int IDE_EN_BIT  = 11,
  parameter int IDE_SEC_BIT = 9,
  parameter int IDE_REG_LSB = 6,
  parameter int IDE_REG_W   = 3,
  parameter int ROM_BIT     = 15,
  parameter int SCSI_AW     = 8,
  parameter int CTL_AW      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scsi_fitted_i,
  input  logic [ID_W-1:0]      scsi_id_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 word_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [15:0]          wdata_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic [15:0]          rdata_o,
  output logic                 ide_rd_o,
  output logic                 ide_wr_o,
  output logic                 ide_word_o,
  output logic [1:0]           ide_cs_o,
  output logic [IDE_REG_W-1:0] ide_reg_o,
  output logic [15:0]          ide_wdata_o,
  input  logic [15:0]          ide_rdata_i,
  output logic                 scsi_rd_o,
  output logic                 scsi_wr_o,
  output logic [SCSI_AW-1:0]   scsi_addr_o,
  output logic [7:0]           scsi_wdata_o,
  input  logic [7:0]           scsi_rdata_i,
  output logic                 ctl_wr_o,
  output logic [CTL_AW-1:0]    ctl_addr_o,
  output logic [7:0]           ctl_wdata_o,
  output logic                 rom_rd_o,
  output logic [ROM_BIT-1:0]   rom_addr_o,
  input  logic [7:0]           rom_rdata_i
);
  logic             b_act, b_we, b_wd, b_last, b_hi, b_lo;
  logic [OFF_W-1:0] b_off;
  logic [7:0]       b_wbyte, rbyte;

  exp_beat_seq #(
    .OFF_W(OFF_W), .IDE_EN_BIT(IDE_EN_BIT), .IDE_REG_LSB(IDE_REG_LSB),
    .IDE_REG_W(IDE_REG_W), .ROM_BIT(ROM_BIT)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .word_i, .off_i, .wdata_i, .ready_o,
    .beat_act_o(b_act), .beat_we_o(b_we), .beat_off_o(b_off),
    .beat_wbyte_o(b_wbyte), .beat_word_data_o(b_wd), .beat_last_o(b_last),
    .beat_hi_o(b_hi), .beat_lo_o(b_lo)
  );

  exp_byte_route #(
    .OFF_W(OFF_W), .ID_W(ID_W), .IDE_EN_BIT(IDE_EN_BIT), .IDE_SEC_BIT(IDE_SEC_BIT),
    .IDE_REG_LSB(IDE_REG_LSB), .IDE_REG_W(IDE_REG_W), .ROM_BIT(ROM_BIT),
    .SCSI_AW(SCSI_AW), .CTL_AW(CTL_AW)
  ) u_route (
    .act_i(b_act), .we_i(b_we), .word_data_i(b_wd), .off_i(b_off),
    .wbyte_i(b_wbyte), .wword_i(wdata_i), .scsi_fitted_i, .scsi_id_i,
    .ide_rd_o, .ide_wr_o, .ide_word_o, .ide_cs_o, .ide_reg_o, .ide_wdata_o, .ide_rdata_i,
    .scsi_rd_o, .scsi_wr_o, .scsi_addr_o, .scsi_wdata_o, .scsi_rdata_i,
    .ctl_wr_o, .ctl_addr_o, .ctl_wdata_o, .rom_rd_o, .rom_addr_o, .rom_rdata_i,
    .rbyte_o(rbyte)
  );

  exp_resp_reg u_resp (
    .clk_i, .rst_ni, .beat_act_i(b_act), .beat_we_i(b_we), .beat_last_i(b_last),
    .beat_hi_i(b_hi), .beat_lo_i(b_lo), .beat_word_data_i(b_wd),
    .rbyte_i(rbyte), .ide_rdata_i, .done_o, .rdata_o
  );
endmodule

// File: rtl/exp_card_decoder_chk.sv
module exp_card_decoder_chk #(
  parameter int OFF_W       = 16,
  parameter int IDE_EN_BIT  = 11,
  parameter int IDE_REG_LSB = 6,
  parameter int ROM_BIT     = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scsi_fitted_i,
  input logic             req_i,
  input logic             we_i,
  input logic             word_i,
  input logic [OFF_W-1:0] off_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             ide_rd_o,
  input logic             ide_wr_o,
  input logic             ide_word_o,
  input logic [1:0]       ide_cs_o,
  input logic             scsi_rd_o,
  input logic             scsi_wr_o,
  input logic             ctl_wr_o,
  input logic             rom_rd_o
);
  logic data_word_req;
  assign data_word_req = req_i && ready_o && word_i && off_i[IDE_EN_BIT]
                         && !off_i[ROM_BIT] && (off_i[IDE_REG_LSB +: 3] == 3'd0);

  p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ide_rd_o || ide_wr_o) |-> $onehot(ide_cs_o));
  p_no_scsi_absent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scsi_fitted_i |-> !(scsi_rd_o || scsi_wr_o));
  p_rom_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o |-> !(ide_rd_o || ide_wr_o || scsi_rd_o || ctl_wr_o));
  p_data_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_word_req |-> ide_word_o ##1 (done_o && ready_o));
  p_split_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && word_i && !data_word_req) |=> !ready_o);
  p_split_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (ready_o && done_o));
  p_ctl_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_o |-> !(ide_wr_o || scsi_wr_o || ide_rd_o));
  p_byte_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !word_i) |=> done_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && ready_o) |=> !done_o);
endmodule

bind exp_card_decoder exp_card_decoder_chk #(
  .OFF_W(OFF_W), .IDE_EN_BIT(IDE_EN_BIT), .IDE_REG_LSB(IDE_REG_LSB), .ROM_BIT(ROM_BIT)
) u_chk (.*);

// File: tb/tb_exp_card_decoder.sv
module tb_exp_card_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fit = 1'b0;
  logic [2:0] sid = 3'd5;
  logic req = 0, we = 0, word = 0;
  logic [15:0] off = '0, wdata = '0;
  logic ready, done;
  logic [15:0] rdata;
  logic ide_rd, ide_wr, ide_word;
  logic [1:0] ide_cs;
  logic [2:0] ide_reg;
  logic [15:0] ide_wdata, ide_rdata;
  logic scsi_rd, scsi_wr;
  logic [7:0] scsi_addr, scsi_wdata, scsi_rdata;
  logic ctl_wr;
  logic [2:0] ctl_addr;
  logic [7:0] ctl_wdata;
  logic rom_rd;
  logic [14:0] rom_addr;
  logic [7:0] rom_rdata;

  int errs = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // target models derive data from the decoded address
  assign ide_rdata[7:0]  = {1'b0, ide_cs, 2'b10, ide_reg};
  assign ide_rdata[15:8] = ~ide_rdata[7:0];
  assign scsi_rdata = scsi_addr ^ 8'h3C;
  assign rom_rdata  = rom_addr[7:0] ^ {1'b0, rom_addr[14:8]} ^ 8'h96;

  exp_card_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .scsi_fitted_i(fit), .scsi_id_i(sid),
    .req_i(req), .we_i(we), .word_i(word), .off_i(off), .wdata_i(wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .ide_rd_o(ide_rd), .ide_wr_o(ide_wr), .ide_word_o(ide_word), .ide_cs_o(ide_cs),
    .ide_reg_o(ide_reg), .ide_wdata_o(ide_wdata), .ide_rdata_i(ide_rdata),
    .scsi_rd_o(scsi_rd), .scsi_wr_o(scsi_wr), .scsi_addr_o(scsi_addr),
    .scsi_wdata_o(scsi_wdata), .scsi_rdata_i(scsi_rdata),
    .ctl_wr_o(ctl_wr), .ctl_addr_o(ctl_addr), .ctl_wdata_o(ctl_wdata),
    .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_m(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h96;
  endfunction

  function automatic bit ide_byte(input logic [15:0] o);
    return o[11] && o[0] && !o[15];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] o);
    if (o[15]) return rom_m(o[14:0]);
    if (o < 16'h0100) return fit ? (o[7:0] ^ 8'h3C) : 8'hFF;
    if (o == 16'h0401) return fit ? {5'b0, ~sid} : 8'hFF;
    if (ide_byte(o)) return {1'b0, (o[9] ? 2'b10 : 2'b01), 2'b10, o[8:6]};
    return 8'hFF;
  endfunction

  // strobe vector {ide_rd, ide_wr, scsi_rd, scsi_wr, ctl_wr, rom_rd}
  function automatic logic [5:0] exp_strb(input bit w, input logic [15:0] o);
    if (o[15]) return w ? 6'b0 : 6'b000001;
    if (o < 16'h0100) return fit ? (w ? 6'b000100 : 6'b001000) : 6'b0;
    if (w && o >= 16'h0400 && o <= 16'h0407) return 6'b000010;
    if (!w && o == 16'h0401) return 6'b0;
    if (ide_byte(o)) return w ? 6'b010000 : 6'b100000;
    return 6'b0;
  endfunction

  function automatic logic [5:0] strb();
    return {ide_rd, ide_wr, scsi_rd, scsi_wr, ctl_wr, rom_rd};
  endfunction

  // checks one byte beat currently on the target ports
  task automatic beat_chk(input bit w, input logic [15:0] o, input logic [7:0] b, input string tag);
    logic [5:0] e;
    bit ok;
    e = exp_strb(w, o);
    ok = (strb() == e);
    if (ok && e[4]) ok = (ide_reg == o[8:6]) && (ide_cs == (o[9] ? 2'b10 : 2'b01)) && (ide_wdata == {8'h00, b});
    if (ok && e[5]) ok = (ide_reg == o[8:6]) && (ide_cs == (o[9] ? 2'b10 : 2'b01));
    if (ok && e[2]) ok = (scsi_addr == o[7:0]) && (scsi_wdata == b);
    if (ok && e[1]) ok = (ctl_addr == o[2:0]) && (ctl_wdata == b);
    if (ok && e[0]) ok = (rom_addr == o[14:0]);
    chk(ok, tag, {10'd0, strb(), o}, {10'd0, e, o});
  endtask

  // assumes call just after a posedge
  task automatic byte_acc(input bit w, input logic [15:0] o, input logic [7:0] b, input string tag);
    req = 1; we = w; word = 0; off = o; wdata = {8'h00, b};
    #1 beat_chk(w, o, b, tag);
    @(posedge clk); #1;
    req = 0;
    if (w) chk(done === 1'b1, "R11 write done", {31'd0, done}, 32'd1);
    else chk(done === 1'b1 && rdata === {8'h00, exp_rd(o)}, tag, {15'd0, done, rdata}, {16'd1, 8'h00, exp_rd(o)});
  endtask

  task automatic split_acc(input bit w, input logic [15:0] o, input logic [15:0] d);
    logic [15:0] o2;
    o2 = o + 16'd1;
    req = 1; we = w; word = 1; off = o; wdata = d;
    #1 beat_chk(w, o, d[15:8], "R8 first beat");
    @(posedge clk); #1;
    req = 0;
    chk(ready === 1'b0 && done === 1'b0, "R8 ready low in second beat", {30'd0, ready, done}, 32'd0);
    beat_chk(w, o2, d[7:0], "R8 second beat");
    @(posedge clk); #1;
    if (w) chk(done === 1'b1, "R8 split write done", {31'd0, done}, 32'd1);
    else chk(done === 1'b1 && rdata === {exp_rd(o), exp_rd(o2)}, "R8 split read data",
             {15'd0, done, rdata}, {16'd1, exp_rd(o), exp_rd(o2)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2;
    chk(ready === 1'b1 && done === 1'b0 && rdata === 16'h0 && strb() === 6'b0,
        "R1 reset state", {8'd0, ready, done, strb(), rdata}, {8'd0, 1'b1, 1'b0, 6'b0, 16'h0});
    #(3*CLK_PERIOD);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(ready === 1'b1 && done === 1'b0 && strb() === 6'b0, "R1 idle after reset",
        {30'd0, ready, done}, 32'h2);

    // sweeps: R2 R3 R4 R5 R9 R10
    for (int f = 0; f < 2; f++) begin
      fit = f[0];
      for (int a = 0; a < 4096; a++) byte_acc(0, a[15:0], 8'h00, "R2/R3/R4/R5/R10 byte read");
      for (int a = 0; a < 4096; a++) byte_acc(1, a[15:0], a[7:0] ^ 8'h5A, "R2/R3/R4/R9/R10 byte write");
      // ROM region R6
      for (int a = 0; a < 300; a++) byte_acc(0, 16'h8000 + 16'(a * 97), 8'h00, "R6 rom read");
      byte_acc(0, 16'h8801, 8'h00, "R6 rom over ide bits");
      byte_acc(1, 16'h8801, 8'hEE, "R6 rom write ignored");
      byte_acc(1, 16'hFFFF, 8'hEE, "R6 rom write ignored top");
      byte_acc(0, 16'h1A01, 8'h00, "R10 unmapped above sweep");
    end

    // R5 other ID value
    fit = 1; sid = 3'd0;
    byte_acc(0, 16'h0401, 8'h00, "R5 id zero");
    sid = 3'd7;
    byte_acc(0, 16'h0401, 8'h00, "R5 id seven");

    // R7 data register word
    for (int k = 0; k < 2; k++) begin
      logic [15:0] o;
      logic [7:0] lo;
      o = k[0] ? 16'h0A00 : 16'h0800;
      lo = {1'b0, (k[0] ? 2'b10 : 2'b01), 2'b10, 3'b000};
      req = 1; we = 0; word = 1; off = o;
      #1 chk(ide_rd && ide_word && ide_reg == 3'd0 && ide_cs == (k[0] ? 2'b10 : 2'b01),
             "R7 data word read strobe", {26'd0, strb()}, 32'h20);
      @(posedge clk); #1; req = 0;
      chk(done === 1'b1 && ready === 1'b1 && rdata === {~lo, lo}, "R7 data word read",
          {15'd0, done, rdata}, {16'd1, ~lo, lo});
    end
    req = 1; we = 1; word = 1; off = 16'h0801; wdata = 16'h1234;
    #1 chk(ide_wr && ide_word && ide_wdata == 16'h1234 && ide_cs == 2'b01,
           "R7 data word write", {16'd0, ide_wdata}, 32'h1234);
    @(posedge clk); #1; req = 0;
    chk(done === 1'b1, "R7 write done", {31'd0, done}, 32'd1);

    // R8 split accesses
    fit = 1; sid = 3'd5;
    split_acc(0, 16'h0880, 16'h0);
    split_acc(0, 16'h0A41, 16'h0);
    split_acc(0, 16'h8000, 16'h0);
    split_acc(0, 16'h9FFE, 16'h0);
    split_acc(0, 16'h0010, 16'h0);
    split_acc(0, 16'h00FF, 16'h0);
    split_acc(0, 16'hFFFF, 16'h0);
    split_acc(1, 16'h0A40, 16'hABCD);
    split_acc(1, 16'h0404, 16'h5566);
    split_acc(1, 16'h8000, 16'h7788);
    fit = 0;
    split_acc(0, 16'h0020, 16'h0);
    split_acc(1, 16'h0020, 16'h99AA);

    // R11 one-cycle done pulse
    @(posedge clk); #1;
    chk(done === 1'b0, "R11 done is a pulse", {31'd0, done}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule